// File: doc/BRIEF.md
# Bidirectional Universal Shift Register

This block is a small register whose contents are rewritten on every rising clock edge according to a two-bit operation select. It can keep its word, move it one place toward the low-order end, move it one place toward the high-order end, or take a whole new word from a parallel input. Each shift direction has its own serial input that supplies the bit entering the register. The full stored word is always visible on a parallel output.

The high-order bit is the "first" position. A shift toward the low-order end moves data away from it and drops the old low-order bit. An active-low clear empties the register at once, with no clock edge needed. To make the register rotate, connect the low-order output bit back to the serial input used by right shifts and select right shift repeatedly. This loop lives outside the block.

Top module: `bidir_shift_reg`

## Requirements
- R1: With `mode` = 2'b00 (hold), a rising edge leaves `par_out` unchanged.
- R2: With `mode` = 2'b01 (shift right), a rising edge makes `par_out` = {`ser_right_in`, old `par_out[3:1]`}. `ser_right_in` enters bit 3, the high-order bit, and old bit 0 is lost.
- R3: With `mode` = 2'b10 (shift left), a rising edge makes `par_out` = {old `par_out[2:0]`, `ser_left_in`}. `ser_left_in` enters bit 0 and old bit 3 is lost.
- R4: With `mode` = 2'b11 (load), a rising edge copies `par_in` into `par_out` bit for bit, with `par_in[3]` landing in `par_out[3]`.
- R5: `par_out` changes only at a rising clock edge. Changes to `mode`, `par_in` or the serial inputs between edges have no effect until the next edge, and all bits update at that edge together.
- R6: Driving `clr_n` low forces `par_out` to 4'b0000 at once, without waiting for a clock edge.
- R7: Clear overrides every mode. While `clr_n` is low, clock edges leave `par_out` at zero. After release, the next edge acts normally.
- R8: If `ser_right_in` is fed from `par_out[0]` and shift right is applied repeatedly, 4'b1000 steps to 4'b0100, 4'b0010, 4'b0001 and back to 4'b1000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all operations occur on its rising edge |
| clr_n | input | 1 | Active-low asynchronous clear |
| mode | input | 2 | Operation select: 00 hold, 01 shift right, 10 shift left, 11 load |
| ser_right_in | input | 1 | Bit entering the high-order position on a right shift |
| ser_left_in | input | 1 | Bit entering the low-order position on a left shift |
| par_in | input | 4 | Parallel load word; bit 3 is the high-order bit |
| par_out | output | 4 | Stored word; bit 3 is the high-order bit |

## Verification
The bench builds the register at its default width of four bits. At that width every combination is small enough to sweep: all sixteen starting words, all four operations and all four pairs of serial inputs, each checked against an arithmetic model. A long random run of mixed operations follows. It checks the rotation loop through the external feedback, clear asserted between edges while a load is pending, and mid-cycle input changes that must not reach the output.

// File: rtl/bsr_pkg.sv
`timescale 1ns/1ps
package bsr_pkg;

  // Operation select; the encoding is visible at the block's port.
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'b00,
    MODE_RIGHT = 2'b01,
    MODE_LEFT  = 2'b10,
    MODE_LOAD  = 2'b11
  } shift_mode_e;

endpackage

// File: rtl/bsr_next_state.sv
`timescale 1ns/1ps
// Computes the next word and the register clock enable from the
// current word, the operation select and the incoming data.
module bsr_next_state
  import bsr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  shift_mode_e        mode_i,
  input  logic [WIDTH-1:0]   q_i,
  input  logic               right_in_i,
  input  logic               left_in_i,
  input  logic [WIDTH-1:0]   load_i,
  output logic [WIDTH-1:0]   q_next_o,
  output logic               en_o
);

  localparam int MSB = WIDTH - 1;

  // Hold is expressed as a disabled clock enable, not a recirculating mux.
  assign en_o = (mode_i != MODE_HOLD);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic from_higher;  // source when moving toward bit 0
    logic from_lower;   // source when moving toward the MSB
    logic nb;

    if (i == MSB) begin : g_top
      assign from_higher = right_in_i;
    end else begin : g_mid_hi
      assign from_higher = q_i[i+1];
    end

    if (i == 0) begin : g_bot
      assign from_lower = left_in_i;
    end else begin : g_mid_lo
      assign from_lower = q_i[i-1];
    end

    always_comb begin
      unique case (mode_i)
        MODE_RIGHT: nb = from_higher;
        MODE_LEFT:  nb = from_lower;
        MODE_LOAD:  nb = load_i[i];
        default:    nb = q_i[i];
      endcase
    end

    assign q_next_o[i] = nb;
  end

endmodule

// File: rtl/bsr_state_reg.sv
`timescale 1ns/1ps
// Storage word with asynchronous active-low clear and a clock enable.
module bsr_state_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      q <= '0;
    end else if (en) begin
      q <= d;
    end
  end

endmodule

// File: rtl/bidir_shift_reg.sv
`timescale 1ns/1ps
// Universal bidirectional shift register, top level.
module bidir_shift_reg
  import bsr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [1:0]       mode,
  input  logic             ser_right_in,
  input  logic             ser_left_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] par_out
);

  shift_mode_e      mode_sel;
  logic [WIDTH-1:0] word_q;
  logic [WIDTH-1:0] word_next;
  logic             word_en;

  assign mode_sel = shift_mode_e'(mode);

  bsr_next_state #(.WIDTH(WIDTH)) u_next (
    .mode_i     (mode_sel),
    .q_i        (word_q),
    .right_in_i (ser_right_in),
    .left_in_i  (ser_left_in),
    .load_i     (par_in),
    .q_next_o   (word_next),
    .en_o       (word_en)
  );

  bsr_state_reg #(.WIDTH(WIDTH)) u_reg (
    .clk   (clk),
    .clr_n (clr_n),
    .en    (word_en),
    .d     (word_next),
    .q     (word_q)
  );

  assign par_out = word_q;

endmodule

// File: rtl/bsr_checker.sv
`timescale 1ns/1ps
module bsr_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clr_n,
  input logic [1:0]       mode,
  input logic             ser_right_in,
  input logic             ser_left_in,
  input logic [WIDTH-1:0] par_in,
  input logic [WIDTH-1:0] par_out
);

  a_r1_hold: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == 2'b00) |=> $stable(par_out));

  a_r2_shift_right: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == 2'b01) |=> par_out == {$past(ser_right_in), $past(par_out[WIDTH-1:1])});

  a_r3_shift_left: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == 2'b10) |=> par_out == {$past(par_out[WIDTH-2:0]), $past(ser_left_in)});

  a_r4_load: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == 2'b11) |=> par_out == $past(par_in));

  // R6 and R7: while clear is low the word reads zero at every edge.
  a_r7_clear_dominates: assert property (@(posedge clk)
    (clr_n === 1'b0) |-> (par_out == '0));

endmodule

bind bidir_shift_reg bsr_checker #(.WIDTH(WIDTH)) u_bsr_checker (
  .clk          (clk),
  .clr_n        (clr_n),
  .mode         (mode),
  .ser_right_in (ser_right_in),
  .ser_left_in  (ser_left_in),
  .par_in       (par_in),
  .par_out      (par_out)
);

// File: tb/tb_bidir_shift_reg.sv
`timescale 1ns/1ps
module tb_bidir_shift_reg;

  logic       clk;
  logic       clr_n;
  logic [1:0] mode;
  logic       ser_right_in;
  logic       ser_left_in;
  logic [3:0] par_in;
  logic [3:0] par_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  bidir_shift_reg #(.WIDTH(4)) dut (
    .clk(clk), .clr_n(clr_n), .mode(mode),
    .ser_right_in(ser_right_in), .ser_left_in(ser_left_in),
    .par_in(par_in), .par_out(par_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Expected next word, computed arithmetically from the requirements.
  function automatic logic [3:0] model(logic [3:0] q, logic [1:0] md,
                                       logic sr, logic sl, logic [3:0] d);
    int v;
    case (md)
      2'b01:   v = (int'(q) >> 1) + (sr ? 8 : 0);
      2'b10:   v = ((int'(q) * 2) % 16) + (sl ? 1 : 0);
      2'b11:   v = int'(d);
      default: v = int'(q);
    endcase
    return v[3:0];
  endfunction

  function automatic string mode_tag(logic [1:0] md);
    case (md)
      2'b00:   return "R1 hold";
      2'b01:   return "R2 shift right";
      2'b10:   return "R3 shift left";
      default: return "R4 load";
    endcase
  endfunction

  task automatic check(string tag, logic [3:0] exp);
    n_checks++;
    if (par_out !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, par_out, exp);
    end
  endtask

  // Advance past the next rising edge and settle for sampling.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(logic [1:0] md, logic sr, logic sl, logic [3:0] d);
    mode = md; ser_right_in = sr; ser_left_in = sl; par_in = d;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #900000;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [3:0] exp;
    clr_n = 1'b0;
    drive(2'b11, 1'b1, 1'b1, 4'b1111);
    tick();
    tick();
    check("R7 reset state under load", 4'b0000);
    clr_n = 1'b1;
    exp = 4'b0000;

    // Exhaustive sweep: every start word, operation and serial pair.
    for (int st = 0; st < 16; st++) begin
      for (int md = 0; md < 4; md++) begin
        for (int s = 0; s < 4; s++) begin
          drive(2'b11, 1'b0, 1'b0, st[3:0]);
          tick();
          check("R4 load start word", st[3:0]);
          drive(md[1:0], s[1], s[0], ~st[3:0]);
          tick();
          check(mode_tag(md[1:0]), model(st[3:0], md[1:0], s[1], s[0], ~st[3:0]));
        end
      end
    end
    exp = par_out;

    // R5: inputs changed between edges do not reach the output.
    drive(2'b11, 1'b1, 1'b1, ~exp);
    #1;
    check("R5 no change between edges", exp);
    drive(2'b01, 1'b0, 1'b1, exp);
    #1;
    check("R5 no change between edges", exp);
    tick();
    exp = model(exp, 2'b01, 1'b0, 1'b1, exp);
    check("R5 all bits at the edge", exp);

    // Random sequence of operations against the model.
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] md;
      logic       sr, sl;
      logic [3:0] d;
      md = 2'($urandom); sr = 1'($urandom); sl = 1'($urandom); d = 4'($urandom);
      drive(md, sr, sl, d);
      tick();
      exp = model(exp, md, sr, sl, d);
      check(mode_tag(md), exp);
    end

    // R8: rotation through external feedback from bit 0.
    drive(2'b11, 1'b0, 1'b0, 4'b1000);
    tick();
    check("R8 rotation seed", 4'b1000);
    drive(2'b01, par_out[0], 1'b0, 4'b0000);
    tick(); check("R8 rotation step 1", 4'b0100);
    ser_right_in = par_out[0];
    tick(); check("R8 rotation step 2", 4'b0010);
    ser_right_in = par_out[0];
    tick(); check("R8 rotation step 3", 4'b0001);
    ser_right_in = par_out[0];
    tick(); check("R8 rotation wrap", 4'b1000);

    // R6 / R7: clear in the middle of a cycle, with a load pending.
    drive(2'b11, 1'b0, 1'b0, 4'b1011);
    tick();
    check("R4 load before clear", 4'b1011);
    drive(2'b11, 1'b1, 1'b1, 4'b1111);
    #0.5;
    clr_n = 1'b0;
    #0.5;
    check("R6 clear without clock edge", 4'b0000);
    for (int n = 0; n < 3; n++) begin
      tick();
      check("R7 edges ignored during clear", 4'b0000);
    end
    drive(2'b01, 1'b1, 1'b1, 4'b0110);
    tick();
    check("R7 shift ignored during clear", 4'b0000);
    clr_n = 1'b1;
    #0.5;
    check("R7 release holds zero until edge", 4'b0000);
    drive(2'b11, 1'b0, 1'b0, 4'b0110);
    tick();
    check("R7 normal load after release", 4'b0110);

    finish_run();
  end

endmodule